// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs the management side of a two-wire PHY access bus. The host places a PHY address, a register address, a direction flag and, for writes, a 16-bit data word on the inputs, then pulses `start`. The block produces a complete register-access frame on the management clock and data pins. It raises `busy` for the length of the frame and pulses `done` once when the frame ends. After a read, the captured word is held on `rd_data`.

The management clock comes from an internal divider. Each low and each high phase of the clock lasts `HALF_DIV` system clock cycles. The default of 40 at a 200 MHz system clock gives a 2.5 MHz management clock. The data output changes only while the clock is low. On a read, the block releases the data pin for exactly one clock pulse and then samples 16 bits while the clock is high. On a write, it drives a 10 turnaround and the data word, then parks the pins with the clock low and the data pin released.

A pin-override mode lets software drive the pins by hand. While `ovr_en` is high, a small register drives the clock, the output enable and the output value, and its read port also returns the live data input. The frame engine cannot be started in this mode.

Top module: `mdio_master`

## Requirements
- R1: Every frame begins with 32 ones, then the start bits 01, then the opcode (10 for read when `op_read`=1, 01 for write), then the 5-bit PHY address and the 5-bit register address, each sent MSB first. Each bit is the value of `mdio_o` with `mdio_oe`=1 at a rising edge of `mdc`.
- R2: A write frame continues with the turnaround bits 10 and then the 16 data bits, MSB first. The frame has 64 `mdc` pulses in total. When `done` is seen, `mdc`=0 and `mdio_oe`=0.
- R3: A read frame holds `mdio_oe`=0 from pulse 47 onward. Pulse 47 is the single turnaround pulse. The next 16 pulses each sample `mdio_i` while `mdc` is high, MSB first, for 63 pulses in total. `rd_data` then holds that word, unchanged through later write frames, until the next read.
- R4: `mdio_o` and `mdio_oe` do not change while `mdc` stays high.
- R5: Every `mdc` high phase lasts exactly `HALF_DIV` system clock cycles, and no low phase inside a frame is shorter.
- R6: `busy` rises in the cycle after an accepted start and falls in the cycle in which `done` is high. `done` is high for one cycle only.
- R7: A `start` pulse during a frame is ignored. The running frame's bits remain those of the original request.
- R8: Pin override register: bit 0 is the clock, bit 1 the output enable (1 = drive), bit 2 the output value, and bit 3 (read only, on `ovr_rdata[3]`) the live `mdio_i`. `ovr_we` loads bits 2:0 from `ovr_wdata`. While `ovr_en`=1, `mdc`, `mdio_oe` and `mdio_o` equal bits 0, 1 and 2.
- R9: While `ovr_en`=1, `start` is rejected: `busy` stays low.
- R10: After reset, `busy`, `done`, `mdc`, `mdio_oe`, `rd_data` and the override bits are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a frame (taken only when idle and not overridden) |
| op_read | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data word for a write frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| rd_data | output | 16 | Word captured by the last read frame |
| mdc | output | 1 | Management clock pin |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |
| ovr_en | input | 1 | Hand pins to the override register |
| ovr_we | input | 1 | Load the override register |
| ovr_wdata | input | 3 | Override bits {value, enable, clock} |
| ovr_rdata | output | 4 | {mdio_i, value, enable, clock} |

## Verification
The assertions assume that `ovr_en` is not switched while a frame is running. Otherwise the hold and phase-length checks would see the pins jump between the engine and the register. The stimulus only changes `ovr_en` while `busy` is low. The bench's PHY model changes `mdio_i` only in the middle of a high phase that comes before the sampling edge, so every captured bit sees a settled input. Frame requests are driven on the falling system clock edge and last exactly one cycle, except for the deliberate mid-frame pulses.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_DIV = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        op_read,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  input  logic        ovr_en,
  input  logic        ovr_we,
  input  logic [2:0]  ovr_wdata,
  output logic [3:0]  ovr_rdata
);

  localparam int CW       = $clog2(HALF_DIV + 1);
  localparam int PW       = $clog2(HALF_DIV + 2);
  localparam int HDR_BITS = 46;
  localparam int WR_SLOTS = 64;
  localparam int RD_SLOTS = HDR_BITS + 1 + 16;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL} st_t;

  st_t         st;
  logic [CW-1:0] div_cnt;
  logic        ph;
  logic [6:0]  slot;
  logic [63:0] sh;
  logic        op_r;
  logic [15:0] rd_q;
  logic        done_q;
  logic [2:0]  pin_r;

  wire tick      = div_cnt == CW'(HALF_DIV - 1);
  wire last_slot = slot == (op_r ? 7'(RD_SLOTS - 1) : 7'(WR_SLOTS - 1));
  wire accept    = start && st == S_IDLE && !ovr_en;
  wire rd_sample = op_r && slot >= 7'(HDR_BITS + 1);

  wire eng_mdc = st == S_RUN && ph;
  wire eng_oe  = (st == S_RUN && (!op_r || slot < 7'(HDR_BITS))) || (st == S_TAIL && !op_r);
  wire eng_o   = eng_oe && sh[63];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      div_cnt <= '0;
      ph      <= 1'b0;
      slot    <= '0;
      sh      <= '0;
      op_r    <= 1'b0;
      rd_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          st      <= S_RUN;
          div_cnt <= '0;
          ph      <= 1'b0;
          slot    <= '0;
          op_r    <= op_read;
          sh      <= {32'hFFFF_FFFF, 2'b01, op_read ? 2'b10 : 2'b01,
                      phy_addr, reg_addr, 2'b10, wr_data};
        end
        S_RUN: begin
          div_cnt <= tick ? '0 : div_cnt + CW'(1);
          if (tick) begin
            if (!ph) ph <= 1'b1;
            else begin
              ph <= 1'b0;
              if (rd_sample) rd_q <= {rd_q[14:0], mdio_i};
              if (last_slot) st <= S_TAIL;
              else begin
                sh   <= sh << 1;
                slot <= slot + 7'd1;
              end
            end
          end
        end
        S_TAIL: begin
          div_cnt <= tick ? '0 : div_cnt + CW'(1);
          if (tick) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pin_r <= '0;
    else if (ovr_we) pin_r <= ovr_wdata;
  end

  assign busy      = st != S_IDLE;
  assign done      = done_q;
  assign rd_data   = rd_q;
  assign mdc       = ovr_en ? pin_r[0] : eng_mdc;
  assign mdio_oe   = ovr_en ? pin_r[1] : eng_oe;
  assign mdio_o    = ovr_en ? pin_r[2] : eng_o;
  assign ovr_rdata = {mdio_i, pin_r};

  logic          eng_mdc_q;
  logic [PW-1:0] ph_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eng_mdc_q <= 1'b0;
      ph_len    <= PW'(HALF_DIV);
    end else begin
      eng_mdc_q <= eng_mdc;
      if (eng_mdc != eng_mdc_q) ph_len <= PW'(1);
      else if (ph_len < PW'(HALF_DIV)) ph_len <= ph_len + PW'(1);
    end
  end

  AST_PHASE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_mdc != eng_mdc_q) |-> ph_len >= PW'(HALF_DIV)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(op_r)); // R7

  AST_OVR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_en && !busy && start) |=> !busy); // R9

  AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_en && $past(!ovr_en) && mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R4

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rd_data)); // R3

endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_read = 1'b0, ovr_en = 1'b0, ovr_we = 1'b0;
  logic [4:0] phy_addr = '0, reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0] ovr_wdata = '0;
  logic busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic [3:0] ovr_rdata;
  logic phy_mi = 1'b0, tb_mi = 1'b0, use_tb_mi = 1'b0;
  wire mdio_i = use_tb_mi ? tb_mi : phy_mi;

  always #2.5 clk = ~clk;

  mdio_master #(.HALF_DIV(HALF)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .start(start), .op_read(op_read),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
    .ovr_en(ovr_en), .ovr_we(ovr_we), .ovr_wdata(ovr_wdata), .ovr_rdata(ovr_rdata)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // PHY model: records driven bits at each MDC rise, drives read data
  logic [63:0] rec_oe, rec_o;
  int n_rise, hi_cnt, bad_len, bad_hold;
  logic mdc_prev = 1'b0, last_o, last_oe;
  logic [15:0] phy_word;

  always @(negedge clk) begin
    if (!ovr_en) begin
      if (mdc && !mdc_prev) begin
        if (n_rise < 64) begin
          rec_oe[63-n_rise] = mdio_oe;
          rec_o[63-n_rise]  = mdio_o;
        end
        last_o = mdio_o;
        last_oe = mdio_oe;
        if (n_rise >= 47 && n_rise < 63) phy_mi = phy_word[62-n_rise];
        n_rise++;
        hi_cnt = 1;
      end else if (mdc) begin
        hi_cnt++;
        if (mdio_o !== last_o || mdio_oe !== last_oe) bad_hold++;
      end else if (mdc_prev) begin
        if (hi_cnt != HALF) bad_len++;
      end
    end
    mdc_prev = mdc;
  end

  localparam logic [42:0] VEC [0:5] = '{
    {1'b1, 5'd1,  5'd2,  16'h0000, 16'hA5C3},
    {1'b0, 5'd31, 5'd0,  16'h8001, 16'h0000},
    {1'b1, 5'd0,  5'd31, 16'h0000, 16'hFFFF},
    {1'b0, 5'd10, 5'd21, 16'h0000, 16'h0000},
    {1'b1, 5'd21, 5'd10, 16'h1234, 16'h0001},
    {1'b0, 5'd5,  5'd17, 16'h5A5A, 16'h0000}
  };

  task automatic run_frame(input logic [42:0] v, input bit poke, input bit have_rd, input logic [15:0] prev_rd);
    logic op = v[42];
    logic [63:0] exp_f = {32'hFFFF_FFFF, 2'b01, op ? 2'b10 : 2'b01, v[41:37], v[36:32], 2'b10, v[31:16]};
    int slots = op ? 63 : 64;
    int wait_n = 0;
    int bad_hdr = 0, bad_tail = 0;
    n_rise = 0; bad_len = 0; bad_hold = 0; rec_oe = '0; rec_o = '0;
    phy_word = v[15:0];
    @(negedge clk);
    op_read = op; phy_addr = v[41:37]; reg_addr = v[36:32]; wr_data = v[31:16];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R6 busy after start", busy, 1);
    if (poke) begin
      repeat (100) @(negedge clk);
      op_read = ~op; phy_addr = ~v[41:37]; wr_data = ~v[31:16]; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R7 busy kept after ignored start", busy, 1);
    end
    while (done !== 1'b1 && wait_n < 2000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(done === 1'b1 && busy === 1'b0, "R6 done with busy low", {done, busy}, 2'b10);
    chk(mdc === 1'b0 && mdio_oe === 1'b0, "R2 pins parked at end", {mdc, mdio_oe}, 0);
    chk(n_rise == slots, op ? "R3 read pulse count" : "R2 write pulse count", n_rise, slots);
    for (int i = 0; i < 64; i++) begin
      if (i < 46) begin
        if (rec_oe[63-i] !== 1'b1 || rec_o[63-i] !== exp_f[63-i]) bad_hdr++;
      end else if (i < slots) begin
        if (op) begin
          if (rec_oe[63-i] !== 1'b0) bad_tail++;
        end else if (rec_oe[63-i] !== 1'b1 || rec_o[63-i] !== exp_f[63-i]) bad_tail++;
      end
    end
    chk(bad_hdr == 0, poke ? "R7 header unchanged by mid-frame start" : "R1 header bits", rec_o, exp_f);
    chk(bad_tail == 0, op ? "R3 released data phase" : "R2 turnaround and data bits", rec_o, exp_f);
    chk(bad_hold == 0, "R4 pins steady while clock high", bad_hold, 0);
    chk(bad_len == 0, "R5 high phase length", bad_len, 0);
    if (op) chk(rd_data === v[15:0], "R3 read word", rd_data, v[15:0]);
    else if (have_rd) chk(rd_data === prev_rd, "R3 read word kept over write", rd_data, prev_rd);
    @(negedge clk);
    chk(done === 1'b0, "R6 done lasts one cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    fails++;
    checks++;
    finish_run();
  end

  initial begin
    bit have_rd = 0;
    logic [15:0] last_rd = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, mdc, mdio_oe} === 4'b0, "R10 reset pins", {busy, done, mdc, mdio_oe}, 0);
    chk(rd_data === 16'h0 && ovr_rdata[2:0] === 3'b0, "R10 reset data and override", {rd_data, ovr_rdata}, 0);

    for (int i = 0; i < 6; i++) begin
      run_frame(VEC[i], (i == 1 || i == 4), have_rd, last_rd);
      if (VEC[i][42]) begin
        have_rd = 1;
        last_rd = VEC[i][15:0];
      end
    end

    // Override mode
    @(negedge clk);
    ovr_en = 1'b1; ovr_we = 1'b1; ovr_wdata = 3'b101;
    @(negedge clk);
    ovr_we = 1'b0;
    chk({mdio_o, mdio_oe, mdc} === 3'b101, "R8 pins follow override bits", {mdio_o, mdio_oe, mdc}, 3'b101);
    use_tb_mi = 1'b1; tb_mi = 1'b1;
    #1;
    chk(ovr_rdata === 4'b1101, "R8 readback with input high", ovr_rdata, 4'b1101);
    tb_mi = 1'b0;
    #1;
    chk(ovr_rdata === 4'b0101, "R8 readback with input low", ovr_rdata, 4'b0101);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b0, "R9 start rejected in override", busy, 0);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && mdc === 1'b1, "R9 pins untouched after rejected start", {busy, mdc}, 2'b01);
    ovr_we = 1'b1; ovr_wdata = 3'b010;
    @(negedge clk);
    ovr_we = 1'b0;
    chk({mdio_o, mdio_oe, mdc} === 3'b010, "R8 drive low via override", {mdio_o, mdio_oe, mdc}, 3'b010);
    ovr_en = 1'b0; use_tb_mi = 1'b0;
    @(negedge clk);
    chk({mdc, mdio_oe} === 2'b00, "R8 engine idle pins after override off", {mdc, mdio_oe}, 0);

    run_frame(VEC[5], 1'b0, have_rd, last_rd);
    finish_run();
  end
endmodule